// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block keeps the event flags of a serial bus controller, gates them with an interrupt enable mask and drives one combined interrupt line and two DMA request lines, one for receive and one for transmit. The transfer engine beside it raises a flag with a one-cycle set pulse. It can also drop a flag with a one-cycle hardware clear pulse. Software reaches the flags, the mask, the DMA enables, a vector register and a test register through a simple single-cycle register port. Read data is combinational.

A parameter selects one of two access styles. In the legacy style the flags are read-only, and reading the vector register both returns and acknowledges the pending enabled source with the lowest number. In the newer style the vector register always reads zero and has no side effect. Software clears flags there by writing ones. Flag positions: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 general call. Register addresses: 0 mask, 1 flags, 2 vector, 3 DMA control, 4 test.

Top module: `irq_vector_unit`

## Requirements
- R1: `irq_o` is high exactly when some flag bit and the same mask bit are both 1.
- R2: In the legacy style, reading address 2 returns one plus the position of the lowest bit set in flags AND mask, or 0 when that AND is zero.
- R3: In the legacy style, a vector read that returns a nonzero value clears that one flag on the following clock edge and leaves the others unchanged.
- R4: In the newer style, address 2 reads 0 and reading it changes no flag.
- R5: In the newer style, writing address 1 clears each flag whose write bit is 1, but only at positions 0, 1, 2 and 5; receive ready (3) and transmit ready (4) are unaffected.
- R6: In the legacy style, writes to address 1 change no flag.
- R7: The mask at address 0 keeps write bits 4:0 in the legacy style and 5:0 in the newer style; the other read bits are 0.
- R8: DMA control at address 3 keeps only write bit 15 (receive DMA enable) and bit 7 (transmit DMA enable); the other read bits are 0.
- R9: A write to address 3 with bit 15 set clears mask bit 3, and with bit 7 set clears mask bit 4.
- R10: `drq_rx_o` equals flag 3 while receive DMA is enabled, and `drq_tx_o` equals flag 4 while transmit DMA is enabled; otherwise each is 0.
- R11: In the newer style, a write to address 4 with bit 11 set sets flags 5:0. In the legacy style this write has no effect.
- R12: When a set pulse and any clear (hardware pulse, one-write clear or vector acknowledge) hit the same flag in one cycle, the flag ends up set.
- R13: Reset clears flags, mask and DMA enables. A set pulse sets its flag on the next edge, and a hardware clear pulse clears its flag on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | NSRC | Per-flag set pulses from the transfer engine |
| hw_clr_i | input | NSRC | Per-flag clear pulses from the transfer engine |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Combined interrupt |
| drq_rx_o | output | 1 | Receive DMA request |
| drq_tx_o | output | 1 | Transmit DMA request |

## Verification
The bench builds the default six-flag configuration twice, once in each access style, and drives both copies with the same stimulus. Because there are only six flags, it can sweep every mask value against every flag pattern. This covers every priority outcome of the vector, every acknowledge, and every one-write clear against the protected ready bits. Directed sequences then cover the DMA interaction with the mask, the test force and same-cycle set/clear collisions.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_VEC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DMA  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TEST = 3'd4;

  localparam int RX_RDY_BIT = 3;
  localparam int TX_RDY_BIT = 4;
  localparam int DMA_RX_POS = 15;
  localparam int DMA_TX_POS = 7;
  localparam int FORCE_POS  = 11;
endpackage

// File: rtl/irqv_rst_sync.sv
module irqv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqv_flags.sv
module irqv_flags #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] flags_q
);
  logic [NSRC-1:0] flags_d;
  logic            flags_en;

  always_comb begin
    flags_en = |(set_vec | clr_vec);
    // set dominates clear on a collision
    flags_d  = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/irqv_cfg.sv
module irqv_cfg
  import irqv_pkg::*;
#(
  parameter int NSRC   = 6,
  parameter int MASK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   mask_o,
  output logic              dma_rx_en,
  output logic              dma_tx_en
);
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              mask_en;
  logic              rx_en_d, tx_en_d;
  logic [MASK_W-1:0] dma_kill;

  always_comb begin
    dma_kill = '0;
    dma_kill[RX_RDY_BIT] = wdata[DMA_RX_POS];
    dma_kill[TX_RDY_BIT] = wdata[DMA_TX_POS];
    mask_en  = mask_we | dma_we;
    if (mask_we) mask_d = wdata[MASK_W-1:0];
    else         mask_d = mask_q & ~dma_kill;
    rx_en_d  = wdata[DMA_RX_POS];
    tx_en_d  = wdata[DMA_TX_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_rx_en <= 1'b0;
      dma_tx_en <= 1'b0;
    end else if (dma_we) begin
      dma_rx_en <= rx_en_d;
      dma_tx_en <= tx_en_d;
    end
  end

  generate
    if (MASK_W < NSRC) begin : g_pad
      assign mask_o = {{(NSRC-MASK_W){1'b0}}, mask_q};
    end else begin : g_full
      assign mask_o = mask_q;
    end
  endgenerate
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int NSRC  = 6,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]  req,
  output logic [IDX_W-1:0] idx,
  output logic [NSRC-1:0]  low_oh
);
  always_comb begin
    idx    = '0;
    low_oh = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = IDX_W'(i + 1);
        low_oh = NSRC'(1) << i;
      end
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int NSRC   = 6,
  parameter bit LEGACY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   set_i,
  input  logic [NSRC-1:0]   hw_clr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              drq_rx_o,
  output logic              drq_tx_o
);
  localparam int MASK_W = LEGACY ? NSRC - 1 : NSRC;
  localparam int IDX_W  = $clog2(NSRC + 1);
  localparam logic [NSRC-1:0] SW_CLR_OK =
    ~((NSRC'(1) << RX_RDY_BIT) | (NSRC'(1) << TX_RDY_BIT));

  logic            rst_sync_n;
  logic [NSRC-1:0] stat_q, mask_q, pend, low_oh;
  logic [NSRC-1:0] set_all, clr_all, ack_clr, w1c_clr, force_set;
  logic [IDX_W-1:0] vec_idx;
  logic [DATA_W-1:0] vec_rdata;
  logic            dma_rx_en, dma_tx_en;
  logic            mask_we, dma_we;

  irqv_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign mask_we = reg_wr_i && (reg_addr_i == A_MASK);
  assign dma_we  = reg_wr_i && (reg_addr_i == A_DMA);

  irqv_cfg #(.NSRC(NSRC), .MASK_W(MASK_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .mask_we(mask_we), .dma_we(dma_we),
    .wdata(reg_wdata_i), .mask_o(mask_q),
    .dma_rx_en(dma_rx_en), .dma_tx_en(dma_tx_en)
  );

  assign pend = stat_q & mask_q;

  irqv_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
    .req(pend), .idx(vec_idx), .low_oh(low_oh)
  );

  generate
    if (LEGACY) begin : g_legacy
      assign vec_rdata = DATA_W'(vec_idx);
      assign ack_clr   = (reg_rd_i && reg_addr_i == A_VEC) ? low_oh : '0;
      assign w1c_clr   = '0;
      assign force_set = '0;
    end else begin : g_newer
      logic unused_idx;
      assign unused_idx = ^{vec_idx, low_oh, reg_rd_i};
      assign vec_rdata = '0;
      assign ack_clr   = '0;
      assign w1c_clr   = (reg_wr_i && reg_addr_i == A_STAT)
                         ? (reg_wdata_i[NSRC-1:0] & SW_CLR_OK) : '0;
      assign force_set = (reg_wr_i && reg_addr_i == A_TEST &&
                          reg_wdata_i[FORCE_POS]) ? '1 : '0;
    end
  endgenerate

  assign set_all = set_i | force_set;
  assign clr_all = hw_clr_i | ack_clr | w1c_clr;

  irqv_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_all), .clr_vec(clr_all),
    .flags_q(stat_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MASK: reg_rdata_o = DATA_W'(mask_q);
      A_STAT: reg_rdata_o = DATA_W'(stat_q);
      A_VEC:  reg_rdata_o = vec_rdata;
      A_DMA: begin
        reg_rdata_o[DMA_RX_POS] = dma_rx_en;
        reg_rdata_o[DMA_TX_POS] = dma_tx_en;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o    = |pend;
  assign drq_rx_o = dma_rx_en & stat_q[RX_RDY_BIT];
  assign drq_tx_o = dma_tx_en & stat_q[TX_RDY_BIT];
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irqv_pkg::*;
#(
  parameter int NSRC   = 6,
  parameter bit LEGACY = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   set_i,
  input logic [NSRC-1:0]   hw_clr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [NSRC-1:0]   stat_q,
  input logic [NSRC-1:0]   mask_q
);
  localparam int MASK_W = LEGACY ? NSRC - 1 : NSRC;

  // R12 / R13: a set pulse always leaves its flag set
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[0] |=> stat_q[0]);

  // R9: receive DMA enable write removes mask bit 3
  p_dma_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_DMA && reg_wdata_i[DMA_RX_POS]) |=> !mask_q[RX_RDY_BIT]);

  // R2: vector never exceeds the number of sources
  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_VEC) |-> (reg_rdata_o <= DATA_W'(NSRC)));

  // R7: mask read never shows bits above its width
  p_mask_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_MASK) |-> (reg_rdata_o >> MASK_W) == '0);

  // R6: legacy flags ignore register writes
  p_stat_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (LEGACY && reg_wr_i && reg_addr_i == A_STAT && !reg_rd_i &&
     set_i == '0 && hw_clr_i == '0) |=> $stable(stat_q));

  // R3: legacy acknowledge drops exactly one flag
  p_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (LEGACY && reg_rd_i && reg_addr_i == A_VEC && reg_rdata_o != '0 &&
     set_i == '0 && hw_clr_i == '0 && !reg_wr_i)
    |=> ($countones(stat_q) + 1 == $countones($past(stat_q))));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.NSRC(NSRC), .LEGACY(LEGACY)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_i(set_i), .hw_clr_i(hw_clr_i),
  .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb;
  localparam int NSRC = 6;

  logic clk, rst_n;
  logic [NSRC-1:0] set_i, hw_clr_i;
  logic reg_wr, reg_rd;
  logic [2:0] addr;
  logic [15:0] wdata;
  logic [15:0] rd_l, rd_n;
  logic irq_l, irq_n, drx_l, drx_n, dtx_l, dtx_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  irq_vector_unit #(.NSRC(NSRC), .LEGACY(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .hw_clr_i(hw_clr_i),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_l), .irq_o(irq_l),
    .drq_rx_o(drx_l), .drq_tx_o(dtx_l));

  irq_vector_unit #(.NSRC(NSRC), .LEGACY(1'b0)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .hw_clr_i(hw_clr_i),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_n), .irq_o(irq_n),
    .drq_rx_o(drx_n), .drq_tx_o(dtx_n));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; set_i = '0; hw_clr_i = '0; wdata = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; reg_wr = 1; cyc(); reg_wr = 0; #1;
  endtask

  task automatic clear_all();
    hw_clr_i = '1; cyc(); hw_clr_i = '0; #1;
  endtask

  task automatic set_flags(input logic [NSRC-1:0] s);
    set_i = s; cyc(); set_i = '0; #1;
  endtask

  function automatic int lowest(input int v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i + 1;
    return 0;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(); addr = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) cyc();
    #1;
    // R13: reset state
    addr = 3'd1; #1; chk("R13 reset flags", rd_l, 0); chk("R13 reset flags n", rd_n, 0);
    addr = 3'd0; #1; chk("R13 reset mask", rd_l, 0);
    addr = 3'd3; #1; chk("R13 reset dma", rd_n, 0);
    chk("R1 reset irq", irq_l | irq_n, 0);

    // exhaustive mask x flag sweep
    for (int m = 0; m < 64; m++) begin
      wr(3'd0, 16'(m) | 16'hFF00);
      addr = 3'd0; #1;
      chk("R7 mask legacy", rd_l, m & 'h1F);
      chk("R7 mask newer", rd_n, m);
      for (int s = 0; s < 64; s++) begin
        int ml, v;
        ml = m & 'h1F;
        v  = lowest(s & ml);
        clear_all();
        set_flags(6'(s));
        addr = 3'd2; reg_rd = 1; #1;
        chk("R1 irq legacy", irq_l, ((s & ml) != 0) ? 1 : 0);
        chk("R1 irq newer", irq_n, ((s & m) != 0) ? 1 : 0);
        chk("R2 vector", rd_l, v);
        chk("R4 vector newer", rd_n, 0);
        cyc(); reg_rd = 0;
        addr = 3'd1; #1;
        chk("R3 ack clear", rd_l, (v == 0) ? s : (s & ~(1 << (v - 1))));
        chk("R4 no side effect", rd_n, s);
        wr(3'd1, 16'hFFFF);
        addr = 3'd1; #1;
        chk("R6 legacy ro", rd_l, (v == 0) ? s : (s & ~(1 << (v - 1))));
        chk("R5 w1c", rd_n, s & 'h18);
      end
    end

    // R8 / R9 / R10 DMA
    clear_all();
    wr(3'd0, 16'h003F);
    wr(3'd3, 16'hFFFF);
    addr = 3'd3; #1;
    chk("R8 dma legacy", rd_l, 'h8080); chk("R8 dma newer", rd_n, 'h8080);
    addr = 3'd0; #1;
    chk("R9 mask legacy", rd_l, 'h07); chk("R9 mask newer", rd_n, 'h27);
    chk("R10 drq idle", drx_l | dtx_l | drx_n | dtx_n, 0);
    set_flags(6'b001000);
    chk("R10 drq rx", drx_l & drx_n, 1); chk("R10 drq tx off", dtx_l | dtx_n, 0);
    set_flags(6'b010000);
    chk("R10 drq tx", dtx_l & dtx_n, 1);
    hw_clr_i = 6'b001000; cyc(); hw_clr_i = '0; #1;
    chk("R13 hw clear rx", drx_l | drx_n, 0);
    chk("R13 hw clear keeps tx", dtx_l, 1);
    wr(3'd3, 16'h0000);
    chk("R10 drq disabled", dtx_l | dtx_n, 0);
    wr(3'd3, 16'h0080);
    addr = 3'd3; #1; chk("R8 tx only", rd_l, 'h0080);

    // R11 test force
    clear_all();
    wr(3'd4, 16'h0800);
    addr = 3'd1; #1;
    chk("R11 force newer", rd_n, 'h3F); chk("R11 legacy ignores", rd_l, 0);
    clear_all();
    wr(3'd4, 16'hF7FF);
    addr = 3'd1; #1; chk("R11 no force bit", rd_n, 0);

    // R12 collisions
    clear_all();
    set_i = 6'b000001; hw_clr_i = 6'b000001; cyc(); idle(); #1;
    addr = 3'd1; #1;
    chk("R12 set vs hw clr legacy", rd_l, 1); chk("R12 set vs hw clr newer", rd_n, 1);
    addr = 3'd1; wdata = 16'h0001; reg_wr = 1; set_i = 6'b000001; cyc(); idle(); #1;
    addr = 3'd1; #1; chk("R12 set vs w1c", rd_n, 1);
    wr(3'd0, 16'h001F);
    addr = 3'd2; reg_rd = 1; set_i = 6'b000001; cyc(); idle(); #1;
    addr = 3'd1; #1; chk("R12 set vs ack", rd_l, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule